// File: doc/BRIEF.md
# Byte-Lane Banked Memory with Per-Lane Address Increment

This block is an on-chip byte-addressable memory that can serve a byte, halfword or word at any byte address in a single access, including accesses that straddle a 32-bit word boundary. Storage is split into four independent byte-wide banks. All four banks share one word address. Each bank can also add one to that shared address on its own. The low two bits of the byte address decide which banks take the incremented address. As a result, a misaligned access fetches or stores its bytes from two adjacent words at the same time, where a single 32-bit-wide memory would need two accesses.

A requester presents a request for one cycle: read or write, a size code and a byte address. Write data sits in the low bytes of the write bus. The block rotates write data onto the byte lanes that hold the addressed bytes. It rotates read data back so that the byte at the requested address appears in bits [7:0]. Memory is little-endian: byte address A lives in bank A[1:0] at word A>>2. Every request gets exactly one response one cycle later. If an access would run past the last byte, the response is flagged as an error and the access does not wrap to address zero.

Top module: `lane_banked_mem`

## Requirements
- R1: After synchronous reset, rsp_valid and rsp_err are 0, and every byte of memory reads back as zero.
- R2: Each request with req_valid high at a rising edge gives exactly one cycle of rsp_valid after the following rising edge. No response appears in a cycle with no request before it.
- R3: A word (req_size 2'b10) written at a word-aligned address reads back unchanged, with byte address A+i in rsp_rdata[8i+7:8i].
- R4: A word read at a byte address whose low bits are not zero, including one that crosses into the next word, returns bytes A..A+3 in one response, with the byte at A in bits [7:0].
- R5: A byte read (2'b00) or halfword read (2'b01) at any offset returns the addressed bytes in the low bits, with the unused upper bits zero.
- R6: A write stores only the 1, 2 or 4 bytes its size covers, taken from the low bytes of req_wdata. This holds even when the bytes span two words. All other bytes keep their contents.
- R7: An access whose last byte (address + size - 1) lies beyond 4*WORDS-1 responds with rsp_err=1 and rsp_rdata=0, and it writes nothing.
- R8: The reserved size code 2'b11 responds with rsp_err=1 and rsp_rdata=0, and it writes nothing.
- R9: A write that is in range responds with rsp_err=0 and rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | BA_W | Byte address |
| req_wdata | input | 32 | Write data, low bytes first |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access out of range or reserved size |
| rsp_rdata | output | 32 | Read data, aligned to bit 0 and zero-extended |

## Verification
The bound checker watches, on every cycle, the one-cycle request-to-response timing, the zero data on errors and on write responses, zero extension for byte reads, and the error flag for reserved sizes and for words that start in the last word at a non-zero offset. The values that come back depend on which bank took the incremented address and how the lanes were rotated. Only the bench can show these: its byte-level model is compared against misaligned reads and writes, partial writes beside untouched neighbours, overruns at the top of memory, and a final read-back sweep of every byte address.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // number of bytes an access touches; zero marks the reserved code
  function automatic logic [2:0] span_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: span_bytes = 3'd1;
      SZ_HALF: span_bytes = 3'd2;
      SZ_WORD: span_bytes = 3'd4;
      default: span_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lbm_lane_map.sv
module lbm_lane_map
  import lbm_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int WA_W  = $clog2(WORDS),
  parameter int BA_W  = WA_W + 2
) (
  input  logic                              valid,
  input  logic                              write,
  input  logic [1:0]                        size,
  input  logic [BA_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [LANES-1:0][WA_W-1:0]        bank_addr,
  output logic [LANES-1:0]                  bank_we,
  output logic [LANES-1:0][LANE_W-1:0]      bank_wdata,
  output logic                              acc_err
);

  localparam int LAST_W = BA_W + 1;
  localparam logic [LAST_W-1:0] LIMIT = LAST_W'(LANES * WORDS - 1);

  logic [WA_W-1:0]   base;
  logic [1:0]        off;
  logic [2:0]        nbytes;
  logic [LAST_W-1:0] last_byte;
  logic              rsvd;

  assign base      = addr[BA_W-1:2];
  assign off       = addr[1:0];
  assign nbytes    = span_bytes(size);
  assign rsvd      = (nbytes == 3'd0);
  assign last_byte = LAST_W'(addr) + LAST_W'(nbytes) - LAST_W'(1);
  assign acc_err   = rsvd || (last_byte > LIMIT);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0] rel;
    logic       plus_one;

    // lanes below the offset hold bytes that belong to the next word
    assign plus_one      = (2'(b) < off);
    assign rel           = 2'(b) - off;
    assign bank_addr[b]  = base + WA_W'(plus_one);
    assign bank_we[b]    = valid & write & ~acc_err & ({1'b0, rel} < nbytes);
    assign bank_wdata[b] = wdata[{rel, 3'b000} +: LANE_W];
  end

endmodule

// File: rtl/lbm_byte_bank.sv
module lbm_byte_bank #(
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH),
  parameter int WIDTH  = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // single-port, read-first, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/lbm_read_align.sv
module lbm_read_align
  import lbm_pkg::*;
(
  input  logic                         enable,
  input  logic [1:0]                   off,
  input  logic [1:0]                   size,
  input  logic [LANES-1:0][LANE_W-1:0] bank_q,
  output logic [DATA_W-1:0]            data
);

  logic [2:0] nbytes;
  assign nbytes = span_bytes(size);

  for (genvar i = 0; i < LANES; i++) begin : g_out
    logic [1:0] src;
    assign src = 2'(i) + off;
    assign data[i*LANE_W +: LANE_W] =
      (enable && (3'(i) < nbytes)) ? bank_q[src] : '0;
  end

endmodule

// File: rtl/lane_banked_mem.sv
module lane_banked_mem
  import lbm_pkg::*;
#(
  parameter  int WORDS = 64,
  localparam int WA_W  = $clog2(WORDS),
  localparam int BA_W  = WA_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [BA_W-1:0] req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [31:0]     rsp_rdata
);

  logic [LANES-1:0][WA_W-1:0]   bank_addr;
  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][LANE_W-1:0] bank_wdata;
  logic [LANES-1:0][LANE_W-1:0] bank_q;
  logic                         acc_err;

  logic       rd_q;
  logic [1:0] off_q;
  logic [1:0] size_q;

  lbm_lane_map #(
    .WORDS (WORDS),
    .WA_W  (WA_W),
    .BA_W  (BA_W)
  ) map_i (
    .valid      (req_valid),
    .write      (req_write),
    .size       (req_size),
    .addr       (req_addr),
    .wdata      (req_wdata),
    .bank_addr  (bank_addr),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .acc_err    (acc_err)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    lbm_byte_bank #(
      .DEPTH (WORDS),
      .AW    (WA_W),
      .WIDTH (LANE_W)
    ) bank_i (
      .clk   (clk),
      .we    (bank_we[b]),
      .addr  (bank_addr[b]),
      .wdata (bank_wdata[b]),
      .rdata (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_q      <= 1'b0;
      off_q     <= 2'b00;
      size_q    <= SZ_BYTE;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & acc_err;
      rd_q      <= req_valid & ~req_write & ~acc_err;
      off_q     <= req_addr[1:0];
      size_q    <= req_size;
    end
  end

  lbm_read_align align_i (
    .enable (rd_q & rsp_valid),
    .off    (off_q),
    .size   (size_q),
    .bank_q (bank_q),
    .data   (rsp_rdata)
  );

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter  int WORDS = 64,
  localparam int WA_W  = $clog2(WORDS),
  localparam int BA_W  = WA_W + 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [1:0]      req_size,
  input logic [BA_W-1:0] req_addr,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [31:0]     rsp_rdata
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_err));

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'b00) |=> (rsp_rdata[31:8] == 24'h0));

  a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

  a_r7_top_word_overrun: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b10 && req_addr[1:0] != 2'b00 &&
     req_addr[BA_W-1:2] == WA_W'(WORDS - 1)) |=> rsp_err);

  a_r8_reserved_size: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b11) |=> rsp_err);

  a_r9_write_no_data: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));

endmodule

bind lane_banked_mem lbm_checker #(.WORDS(WORDS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/lane_banked_mem_tb_top.sv
`timescale 1ns/1ps
module lane_banked_mem_tb_top;

  localparam int WORDS = 64;
  localparam int WA_W  = $clog2(WORDS);
  localparam int BA_W  = WA_W + 2;
  localparam int NBYTE = 4 * WORDS;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [1:0]      req_size  = 2'b00;
  logic [BA_W-1:0] req_addr  = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_err;
  logic [31:0]     rsp_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [NBYTE];
  exp_t       sb_q [$];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  lane_banked_mem #(.WORDS(WORDS)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: predicts the response from the byte model, then presents the request
  task automatic issue(input logic w, input logic [1:0] sz, input int a,
                       input logic [31:0] d, input string tag);
    exp_t e;
    int   n;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
    e.data = '0;
    e.err  = (n == 0) || (a + n - 1 > NBYTE - 1);
    e.tag  = tag;
    if (!e.err) begin
      for (int i = 0; i < n; i++) begin
        if (w) model[a + i] = d[8*i +: 8];
        else   e.data[8*i +: 8] = model[a + i];
      end
    end
    @(negedge clk);
    sb_q.push_back(e);
    req_valid = 1'b1;
    req_write = w;
    req_size  = sz;
    req_addr  = BA_W'(a);
    req_wdata = d;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: compares each response against the oldest prediction
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 response without request", {31'b0, rsp_valid}, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
        check(rsp_err == e.err, {e.tag, " err"}, {31'b0, rsp_err}, {31'b0, e.err});
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTE; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !rsp_err, "R1 reset outputs",
          {30'b0, rsp_valid, rsp_err}, 32'h0);

    // R1: contents start at zero
    issue(1'b0, 2'b10, 0, 0, "R1 zero word 0");
    issue(1'b0, 2'b10, 5, 0, "R1 zero word 5");
    issue(1'b0, 2'b10, NBYTE - 4, 0, "R1 zero top word");

    // R3: aligned word round trip
    issue(1'b1, 2'b10, 8, 32'h1122_3344, "R3 write");
    issue(1'b0, 2'b10, 8, 0, "R3 aligned read");

    // R4: misaligned words crossing a boundary
    issue(1'b1, 2'b10, 16, 32'hA3A2_A1A0, "R4 setup lo");
    issue(1'b1, 2'b10, 20, 32'hB3B2_B1B0, "R4 setup hi");
    issue(1'b0, 2'b10, 17, 0, "R4 read off1");
    issue(1'b0, 2'b10, 18, 0, "R4 read off2");
    issue(1'b0, 2'b10, 19, 0, "R4 read off3");

    // R5: narrow reads at each offset
    for (int a = 16; a < 20; a++) issue(1'b0, 2'b00, a, 0, "R5 byte read");
    issue(1'b0, 2'b01, 17, 0, "R5 half read");
    issue(1'b0, 2'b01, 19, 0, "R5 half read crossing");

    // R6: partial writes leave neighbours alone
    issue(1'b1, 2'b00, 21, 32'hFFFF_FFAA, "R6 byte write");
    issue(1'b1, 2'b01, 23, 32'hFFFF_5566, "R6 half write crossing");
    issue(1'b1, 2'b10, 26, 32'hDDCC_BBEE, "R6 word write crossing");
    issue(1'b0, 2'b10, 20, 0, "R6 readback 20");
    issue(1'b0, 2'b10, 24, 0, "R6 readback 24");
    issue(1'b0, 2'b10, 28, 0, "R6 readback 28");

    // R7: overrun at the top of memory, with no wrap and no write
    issue(1'b1, 2'b10, NBYTE - 4, 32'h0BAD_F00D, "R7 top word setup");
    issue(1'b0, 2'b10, NBYTE - 3, 0, "R7 word overrun read");
    issue(1'b1, 2'b10, NBYTE - 2, 32'h1234_5678, "R7 word overrun write");
    issue(1'b1, 2'b01, NBYTE - 1, 32'h0000_9999, "R7 half overrun write");
    issue(1'b0, 2'b10, NBYTE - 4, 0, "R7 top word unchanged");
    issue(1'b0, 2'b10, 0, 0, "R7 no wrap to zero");
    issue(1'b0, 2'b00, NBYTE - 1, 0, "R7 last byte in range");

    // R8: reserved size
    issue(1'b1, 2'b11, 8, 32'hFFFF_FFFF, "R8 reserved write");
    issue(1'b0, 2'b11, 8, 0, "R8 reserved read");
    issue(1'b0, 2'b10, 8, 0, "R8 word unchanged");

    // R2: a gap with no request gives no response
    idle(3);
    check(!rsp_valid && sb_q.size() == 0, "R2 idle quiet",
          {31'b0, rsp_valid}, 32'h0);

    // R9 and R6: pseudo-random mixed traffic, then a full read-back
    for (int k = 0; k < 400; k++) begin
      logic [1:0] sz;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sz = (lfsr[9:6] == 4'hF) ? 2'b11 : 2'(lfsr[5:4] % 3);
      issue(lfsr[10], sz, int'(lfsr[31:16]) % NBYTE, lfsr ^ 32'h5A5A_3C3C,
            "R9 mixed traffic");
    end
    for (int a = 0; a < NBYTE; a++) issue(1'b0, 2'b10, a, 0, "R6 sweep read");

    idle(4);
    check(sb_q.size() == 0, "R2 all responses seen", sb_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule